// File: doc/BRIEF.md
# Periodic Driver Impedance Calibration Sequencer

This block is the digital part of an output-driver impedance calibration loop. It holds a binary-weighted impedance code that selects which driver legs are switched in. It then keeps that code close to the value that matches an external reference. A free-running interval counter starts an evaluation at a fixed cadence. An analog comparator outside the block reports whether the driver is currently too weak or too strong. At each evaluation the code moves by at most one step in the direction the comparator asks for. The code clamps at both ends and never wraps.

After reset the block has to run for a long settling window (32768 clock cycles by default) before its code counts as valid. Every clock counts toward this window, whatever the rest of the chip is doing. While the window runs, evaluations come at a short boot period, so that the code can travel from mid-scale to either end before the window closes. When the window closes, the ready flag rises and stays high until the next reset. From then on, evaluations continue at the longer run period so that the code follows supply and temperature drift for as long as the block runs.

Top module: `calib_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `imp_code` equals mid-scale (only the most significant bit set, 6'b100000 by default), and `eval_strobe` and `cal_ready` are both 0.
- R2: Before `cal_ready` is high, `eval_strobe` is a one-cycle pulse. It is first high in cycle BOOT_PERIOD after reset release (cycle 0 is the first cycle out of reset), and then every BOOT_PERIOD cycles.
- R3: After `cal_ready` has risen, the next `eval_strobe` pulse comes RUN_PERIOD cycles after the previous one, and the pulses keep that spacing for as long as the block runs.
- R4: At an evaluation, the block uses the comparator value present in the cycle just before `eval_strobe` goes high. A value of 2'b01 (driver too weak) raises `imp_code` by one. A value of 2'b10 (driver too strong) lowers it by one. A value of 2'b00 or 2'b11 leaves it unchanged. The new code appears in the same cycle as `eval_strobe`.
- R5: `imp_code` changes only in a cycle where `eval_strobe` is high, and then only by one step.
- R6: An increment request when the code is all ones leaves it at all ones. A decrement request when the code is all zeros leaves it at all zeros.
- R7: `cal_ready` rises in cycle SETTLE_CYCLES after reset release, whatever comparator values come in. Once high, it stays high until reset.
- R8: Comparator values present in cycles that do not lead into an evaluation have no effect on `imp_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmp_dir | input | 2 | Comparator result: 01 too weak, 10 too strong, 00/11 hold |
| imp_code | output | CODE_W | Binary-weighted driver impedance code |
| eval_strobe | output | 1 | High for the one cycle in which an evaluation result is applied |
| cal_ready | output | 1 | Start-up settling window has elapsed |

## Verification
Suppose the interval counter is out of step. Then `eval_strobe` is early or late, and the fault shows at the very first evaluation (cycle BOOT_PERIOD) or at the first run-period pulse after `cal_ready` rises. Suppose instead the code register steps at the wrong moment or ignores saturation. Then `imp_code` differs from the model in the cycle of that evaluation, or in a cycle where no evaluation happened. A settling counter that is one cycle off shows up in the single cycle where `cal_ready` rises, and the bench compares every output against its own model on every clock, so that cycle is covered.

// File: rtl/calib_pkg.sv
package calib_pkg;

    typedef enum logic [1:0] {
        CMP_HOLD = 2'b00,
        CMP_WEAK = 2'b01,
        CMP_STRONG = 2'b10,
        CMP_BOTH = 2'b11
    } cmp_e;

    typedef enum logic [1:0] {
        DIR_KEEP,
        DIR_UP,
        DIR_DOWN
    } dir_e;

    typedef struct packed {
        logic tick;
        dir_e dir;
    } eval_req_t;

    function automatic dir_e decode_cmp(input cmp_e c);
        case (c)
            CMP_WEAK:   return DIR_UP;
            CMP_STRONG: return DIR_DOWN;
            default:    return DIR_KEEP;
        endcase
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/calib_interval.sv
module calib_interval #(
    parameter int BOOT_PERIOD = 16,
    parameter int RUN_PERIOD  = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run_phase,
    output logic tick
);
    import calib_pkg::*;

    localparam int MAXP = max_int(BOOT_PERIOD, RUN_PERIOD);
    localparam int CW   = (MAXP > 2) ? $clog2(MAXP) : 1;
    localparam logic [CW-1:0] BOOT_LAST = CW'(BOOT_PERIOD - 1);
    localparam logic [CW-1:0] RUN_LAST  = CW'(RUN_PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = run_phase ? RUN_LAST : BOOT_LAST;
    assign tick = (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/calib_settle.sv
module calib_settle #(
    parameter int SETTLE_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int SW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [SW-1:0] LAST = SW'(SETTLE_CYCLES - 1);

    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            if (cnt_q == LAST) begin
                done <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/calib_stepper.sv
module calib_stepper
    import calib_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  eval_req_t         req,
    output logic [CODE_W-1:0] code,
    output logic              strobe
);
    localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] BOT_CODE = '0;
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic [CODE_W-1:0] code_nxt;

    always_comb begin
        code_nxt = code;
        if (req.tick) begin
            case (req.dir)
                DIR_UP:   if (code != TOP_CODE) code_nxt = code + 1'b1;
                DIR_DOWN: if (code != BOT_CODE) code_nxt = code - 1'b1;
                default:  code_nxt = code;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code   <= MID_CODE;
            strobe <= 1'b0;
        end else begin
            code   <= code_nxt;
            strobe <= req.tick;
        end
    end

endmodule

// File: rtl/calib_seq.sv
module calib_seq
    import calib_pkg::*;
#(
    parameter int CODE_W        = 6,
    parameter int BOOT_PERIOD   = 16,
    parameter int RUN_PERIOD    = 256,
    parameter int SETTLE_CYCLES = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmp_dir,
    output logic [CODE_W-1:0] imp_code,
    output logic              eval_strobe,
    output logic              cal_ready
);
    logic      tick;
    eval_req_t req;

    calib_settle #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_settle (
        .clk (clk),
        .rst (rst),
        .done(cal_ready)
    );

    calib_interval #(
        .BOOT_PERIOD(BOOT_PERIOD),
        .RUN_PERIOD (RUN_PERIOD)
    ) u_interval (
        .clk      (clk),
        .rst      (rst),
        .run_phase(cal_ready),
        .tick     (tick)
    );

    assign req.tick = tick;
    assign req.dir  = decode_cmp(cmp_e'(cmp_dir));

    calib_stepper #(
        .CODE_W(CODE_W)
    ) u_stepper (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .code  (imp_code),
        .strobe(eval_strobe)
    );

endmodule

// File: rtl/calib_seq_chk.sv
module calib_seq_chk #(
    parameter int CODE_W        = 6,
    parameter int BOOT_PERIOD   = 16,
    parameter int RUN_PERIOD    = 256,
    parameter int SETTLE_CYCLES = 32768
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cmp_dir,
    input logic [CODE_W-1:0] imp_code,
    input logic              eval_strobe,
    input logic              cal_ready
);
    localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    int gap_q;
    int age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= 0;
            age_q <= 0;
        end else begin
            gap_q <= eval_strobe ? 1 : gap_q + 1;
            if (age_q < SETTLE_CYCLES) age_q <= age_q + 1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (imp_code == MID_CODE && !eval_strobe && !cal_ready));

    // R2 R3
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eval_strobe |=> !eval_strobe);

    // R2 R3
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        eval_strobe |-> (gap_q == ($past(cal_ready) ? RUN_PERIOD : BOOT_PERIOD)));

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (eval_strobe && $past(cmp_dir) == 2'b01 && $past(imp_code) != TOP_CODE)
        |-> (imp_code == $past(imp_code) + 1'b1));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (eval_strobe && ($past(cmp_dir) == 2'b00 || $past(cmp_dir) == 2'b11))
        |-> $stable(imp_code));

    // R5 R8
    change_only_on_eval_chk: assert property (@(posedge clk) disable iff (rst)
        (imp_code != $past(imp_code)) |-> eval_strobe);

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        eval_strobe |-> (((imp_code >= $past(imp_code)) ? (imp_code - $past(imp_code))
                                                        : ($past(imp_code) - imp_code)) <= 1));

    // R6
    top_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (eval_strobe && $past(imp_code) == TOP_CODE && $past(cmp_dir) == 2'b01)
        |-> (imp_code == TOP_CODE));

    // R6
    bottom_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (eval_strobe && $past(imp_code) == '0 && $past(cmp_dir) == 2'b10)
        |-> (imp_code == '0));

    // R7
    ready_time_chk: assert property (@(posedge clk) disable iff (rst)
        cal_ready == (age_q >= SETTLE_CYCLES));

    // R7
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cal_ready) |-> cal_ready);

endmodule

bind calib_seq calib_seq_chk #(
    .CODE_W       (CODE_W),
    .BOOT_PERIOD  (BOOT_PERIOD),
    .RUN_PERIOD   (RUN_PERIOD),
    .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmp_dir    (cmp_dir),
    .imp_code   (imp_code),
    .eval_strobe(eval_strobe),
    .cal_ready  (cal_ready)
);

// File: tb/calib_seq_test.sv
module calib_seq_test;
    localparam int CODE_W = 6;
    localparam int BOOT   = 16;
    localparam int RUN    = 256;
    localparam int SETTLE = 32768;
    localparam int TOPV   = (1 << CODE_W) - 1;
    localparam int MIDV   = 1 << (CODE_W - 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cmp_dir = 2'b00;
    logic [CODE_W-1:0] imp_code;
    logic              eval_strobe;
    logic              cal_ready;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;

    // behavioural reference
    int m_code, m_cnt, m_age, m_prev;
    bit m_ready, m_strobe;

    calib_seq #(
        .CODE_W(CODE_W), .BOOT_PERIOD(BOOT), .RUN_PERIOD(RUN), .SETTLE_CYCLES(SETTLE)
    ) uut (
        .clk(clk), .rst(rst), .cmp_dir(cmp_dir),
        .imp_code(imp_code), .eval_strobe(eval_strobe), .cal_ready(cal_ready)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_code = MIDV; m_cnt = 0; m_age = 0; m_ready = 0; m_strobe = 0;
        end else begin
            int per;
            bit ev;
            per = m_ready ? RUN : BOOT;
            ev = (m_cnt >= per - 1);
            m_cnt = ev ? 0 : m_cnt + 1;
            if (ev && cmp_dir == 2'b01 && m_code < TOPV) m_code = m_code + 1;
            else if (ev && cmp_dir == 2'b10 && m_code > 0) m_code = m_code - 1;
            m_strobe = ev;
            m_age = m_age + 1;
            m_ready = (m_age >= SETTLE);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R4 code", int'(imp_code), m_code);
            check(m_ready ? "R3 strobe" : "R2 strobe", int'(eval_strobe), int'(m_strobe));
            check("R7 ready", int'(cal_ready), int'(m_ready));
            if (!rst && !eval_strobe) check("R5 code moved without eval", int'(imp_code), m_prev);
            m_prev = int'(imp_code);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int saved;
        rst = 1'b1;
        cycles(4);
        check("R1 code in reset", int'(imp_code), MIDV);
        check("R1 strobe in reset", int'(eval_strobe), 0);
        check("R1 ready in reset", int'(cal_ready), 0);
        m_prev = int'(imp_code);
        cmp_on = 1;
        rst = 1'b0;
        cycles(1);
        check("R1 code first cycle", int'(imp_code), MIDV);

        // first boot evaluation lands in cycle BOOT
        cmp_dir = 2'b01;
        cycles(BOOT - 1);
        check("R2 first strobe", int'(eval_strobe), 1);
        check("R4 first increment", int'(imp_code), MIDV + 1);

        cycles(600);
        check("R6 clamp at top", int'(imp_code), TOPV);
        cmp_dir = 2'b10;
        cycles(1100);
        check("R6 clamp at bottom", int'(imp_code), 0);
        cmp_dir = 2'b11;
        cycles(100);
        check("R4 both bits hold", int'(imp_code), 0);

        for (int i = 0; i < 2000; i++) begin
            cmp_dir = 2'($urandom % 4);
            cycles(1);
        end

        // R8: pulses between evaluations do nothing
        cmp_dir = 2'b00;
        while (!eval_strobe) cycles(1);
        saved = int'(imp_code);
        cmp_dir = (saved != 0) ? 2'b10 : 2'b01;
        cycles(6);
        cmp_dir = 2'b00;
        cycles(4);
        check("R8 mid-period request ignored", int'(imp_code), saved);

        cmp_dir = 2'b01;
        cycles(SETTLE + 300 - m_age);
        check("R7 ready after window", int'(cal_ready), 1);

        for (int i = 0; i < 1500; i++) begin
            cmp_dir = 2'($urandom % 4);
            cycles(1);
        end
        check("R7 ready still high", int'(cal_ready), 1);

        rst = 1'b1;
        cycles(2);
        check("R1 ready cleared by reset", int'(cal_ready), 0);
        check("R1 code after second reset", int'(imp_code), MIDV);
        rst = 1'b0;
        cycles(40);
        check("R7 ready low early after reset", int'(cal_ready), 0);
        finish_run();
    end

endmodule